// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It takes the device from power-up to a usable state. It drives the memory reset line, clock enable, on-die-termination enable, the four command strobes, the bank address and the row/column address. The sequence runs as follows:

1. Reset is held low for a set time.
2. Reset is released, and clock enable rises after a further delay.
3. The four mode registers are written in a fixed order.
4. A long ZQ calibration is started.
5. A ready flag is raised once both the DLL-lock time and the ZQ-init time have run out.

Every wait is a cycle count set by a parameter. The mode-register contents arrive as input words. The sequencer overrides the two bits that the sequence itself depends on: the DLL-enable bit and the DLL-reset bit. A sequence starts when the block leaves reset. A one-cycle `start` pulse restarts it from the beginning at any time.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low, `mem_reset_n` = 0, `mem_cke` = 0, `mem_cs_n` = 1 and `init_done` = 0.
- R2: After each launch, `mem_reset_n` stays low for T_RESET_LOW cycles and then goes high. `mem_cke` rises T_RST_CKE cycles after `mem_reset_n` rises.
- R3: The command bus follows the level of `mem_cke`:
  - While `mem_cke` is low, the bus is deselected (`mem_cs_n` = 1).
  - While `mem_cke` is high, every cycle that issues no command carries NOP: {cs_n, ras_n, cas_n, we_n} = 0111.
- R4: The first mode-register write (MRS, strobes 0000) is issued T_XPR cycles after `mem_cke` rises.
- R5: Four MRS commands are issued, each T_MRD cycles after the one before. Each carries its payload word on `mem_addr`. Their order and `mem_ba` values are:
  - MR2, `mem_ba` = 010
  - MR3, `mem_ba` = 011
  - MR1, `mem_ba` = 001
  - MR0, `mem_ba` = 000
- R6: In the MR1 write, address bit 0 is forced to 0 (DLL enabled), whatever `mr1_word[0]` holds.
- R7: In the MR0 write, address bit 8 is forced to 1 (DLL reset), whatever `mr0_word[8]` holds.
- R8: A ZQ calibration long command is issued T_MOD cycles after the MR0 write. Its strobes are 0110, address bit 10 is 1, all other address bits are 0, and `mem_ba` is 000.
- R9: `init_done` rises in the later of two cycles: MR0 cycle + T_DLLK, or ZQCL cycle + T_ZQINIT. It then stays high until the next launch.
- R10: Once `mem_cke` has risen, it stays high until a launch. It never falls while `mem_reset_n` is high.
- R11: `mem_odt` is set while `mem_reset_n` is low and held constant from the rise of `mem_reset_n` onwards. Its value is 0 if any of `mr1_word` bits 2, 6 or 9 is set, and `odt_req` otherwise.
- R12: If `start` is sampled high, then in the next cycle `mem_reset_n` = 0 and `init_done` = 0, and the whole sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the sequence |
| odt_req | input | 1 | Desired static ODT level |
| mr0_word | input | AW | MR0 payload |
| mr1_word | input | AW | MR1 payload |
| mr2_word | input | AW | MR2 payload |
| mr3_word | input | AW | MR3 payload |
| mem_reset_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | Memory termination enable |
| mem_cs_n | output | 1 | Chip select strobe |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write-enable strobe |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | AW | Address bus |
| init_done | output | 1 | Device ready |

## Verification
All outputs are decoded from registered state, so each event appears in the cycle after the clock edge that enters it. The intervals between events are exact cycle counts:
- reset-low length
- reset-to-CKE
- CKE-to-first-MRS
- MRS-to-MRS
- MR0-to-ZQCL
- MR0/ZQCL-to-ready

The bench samples every output at the falling clock edge and timestamps each event with the same cycle counter. It then compares the differences against the parameter values, and compares the ready cycle against the later of the two timer expiries. A second instance with a long ZQ time makes the ZQ timer the one that decides readiness.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [2:0] {
    ST_RST,   // memory reset held low
    ST_CKEW,  // reset released, clock enable still low
    ST_XPR,   // clock enable high, waiting before first MRS
    ST_MRS,   // one mode-register write
    ST_GAP,   // spacing after a mode-register write
    ST_ZQ,    // long ZQ calibration command
    ST_RUN    // waiting for / holding readiness
  } init_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = 4'b1111;
  localparam cmd_t CMD_NOP   = 4'b0111;
  localparam cmd_t CMD_MRS   = 4'b0000;
  localparam cmd_t CMD_ZQCL  = 4'b0110;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int unsigned DELAY = 512,
  parameter int unsigned CW    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  output logic expired
);

  logic [CW-1:0] rem_q, rem_d;
  logic          run_q, run_d;
  logic          upd_en;

  always_comb begin
    rem_d  = rem_q;
    run_d  = run_q;
    upd_en = 1'b0;
    if (clr) begin
      rem_d  = '0;
      run_d  = 1'b0;
      upd_en = 1'b1;
    end else if (trig) begin
      rem_d  = CW'(DELAY - 1);
      run_d  = 1'b1;
      upd_en = 1'b1;
    end else if (run_q && (rem_q != '0)) begin
      rem_d  = rem_q - 1'b1;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      rem_q <= rem_d;
      run_q <= run_d;
    end
  end

  assign expired = run_q && (rem_q == '0);

endmodule

// File: rtl/ddr3_init_cmdgen.sv
module ddr3_init_cmdgen
  import ddr3_init_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  init_st_e        st,
  input  logic [1:0]      slot,
  input  logic [AW-1:0]   mr0_word,
  input  logic [AW-1:0]   mr1_word,
  input  logic [AW-1:0]   mr2_word,
  input  logic [AW-1:0]   mr3_word,
  output cmd_t            cmd,
  output logic [2:0]      ba,
  output logic [AW-1:0]   addr
);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 3'b000;
    addr = '0;
    unique case (st)
      ST_RST, ST_CKEW: cmd = CMD_DESEL;
      ST_MRS: begin
        cmd = CMD_MRS;
        // slot is the position in the load order, not the register number
        unique case (slot)
          2'd0: begin ba = 3'b010; addr = mr2_word; end
          2'd1: begin ba = 3'b011; addr = mr3_word; end
          2'd2: begin
            ba      = 3'b001;
            addr    = mr1_word;
            addr[0] = 1'b0;   // keep the DLL on
          end
          default: begin
            ba      = 3'b000;
            addr    = mr0_word;
            addr[8] = 1'b1;   // request DLL reset
          end
        endcase
      end
      ST_ZQ: begin
        cmd      = CMD_ZQCL;
        addr[10] = 1'b1;
      end
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter int unsigned T_RESET_LOW = 20000,
  parameter int unsigned T_RST_CKE   = 50000,
  parameter int unsigned T_XPR       = 12,
  parameter int unsigned T_MRD       = 4,
  parameter int unsigned T_MOD       = 12,
  parameter int unsigned T_DLLK      = 512,
  parameter int unsigned T_ZQINIT    = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          odt_req,
  input  logic [AW-1:0] mr0_word,
  input  logic [AW-1:0] mr1_word,
  input  logic [AW-1:0] mr2_word,
  input  logic [AW-1:0] mr3_word,
  output logic          mem_reset_n,
  output logic          mem_cke,
  output logic          mem_odt,
  output logic          mem_cs_n,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic [2:0]    mem_ba,
  output logic [AW-1:0] mem_addr,
  output logic          init_done
);

  localparam int unsigned WAIT_MAX =
    max2(max2(T_RESET_LOW, T_RST_CKE), max2(T_XPR, max2(T_MRD, T_MOD)));
  localparam int unsigned SW   = $clog2(WAIT_MAX + 1);
  localparam int unsigned TW   = $clog2(max2(T_DLLK, T_ZQINIT) + 1);
  localparam logic [1:0]  LAST_SLOT = 2'd3;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  init_st_e      st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic [1:0]    slot_q, slot_d;
  logic          seq_en;
  logic          odt_q, odt_d, odt_en;
  int unsigned   wait_len;
  logic          step_last;

  always_comb begin
    unique case (st_q)
      ST_RST:  wait_len = T_RESET_LOW;
      ST_CKEW: wait_len = T_RST_CKE;
      ST_XPR:  wait_len = T_XPR;
      ST_GAP:  wait_len = (slot_q == LAST_SLOT) ? (T_MOD - 1) : (T_MRD - 1);
      default: wait_len = 1;
    endcase
  end

  assign step_last = (cnt_q == SW'(wait_len - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    slot_d = slot_q;
    seq_en = (st_q != ST_RUN);
    if (start) begin
      st_d   = ST_RST;
      cnt_d  = '0;
      slot_d = 2'd0;
      seq_en = 1'b1;
    end else if (step_last && (st_q != ST_RUN)) begin
      cnt_d = '0;
      unique case (st_q)
        ST_RST:  st_d = ST_CKEW;
        ST_CKEW: st_d = ST_XPR;
        ST_XPR:  st_d = ST_MRS;
        ST_MRS:  st_d = ST_GAP;
        ST_GAP: begin
          if (slot_q == LAST_SLOT) begin
            st_d = ST_ZQ;
          end else begin
            st_d   = ST_MRS;
            slot_d = slot_q + 1'b1;
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_RST;
      cnt_q  <= '0;
      slot_q <= 2'd0;
    end else if (seq_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  // ODT level is captured while the memory is held in reset, then frozen
  assign odt_en = (st_q == ST_RST);
  assign odt_d  = odt_req & ~(mr1_word[2] | mr1_word[6] | mr1_word[9]);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      odt_q <= 1'b0;
    end else if (odt_en) begin
      odt_q <= odt_d;
    end
  end

  // two independent, overlapping readiness timers
  logic tmr_clr, dll_trig, zq_trig, dll_exp, zq_exp;
  assign tmr_clr  = start | (st_q == ST_RST);
  assign dll_trig = (st_q == ST_MRS) && (slot_q == LAST_SLOT);
  assign zq_trig  = (st_q == ST_ZQ);

  ddr3_init_timer #(.DELAY(T_DLLK), .CW(TW)) u_dll_tmr (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (tmr_clr),
    .trig    (dll_trig),
    .expired (dll_exp)
  );

  ddr3_init_timer #(.DELAY(T_ZQINIT), .CW(TW)) u_zq_tmr (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (tmr_clr),
    .trig    (zq_trig),
    .expired (zq_exp)
  );

  cmd_t cmd;
  ddr3_init_cmdgen #(.AW(AW)) u_cmdgen (
    .st       (st_q),
    .slot     (slot_q),
    .mr0_word (mr0_word),
    .mr1_word (mr1_word),
    .mr2_word (mr2_word),
    .mr3_word (mr3_word),
    .cmd      (cmd),
    .ba       (mem_ba),
    .addr     (mem_addr)
  );

  assign mem_cs_n    = cmd.cs_n;
  assign mem_ras_n   = cmd.ras_n;
  assign mem_cas_n   = cmd.cas_n;
  assign mem_we_n    = cmd.we_n;
  assign mem_reset_n = (st_q != ST_RST);
  assign mem_cke     = (st_q != ST_RST) && (st_q != ST_CKEW);
  assign mem_odt     = odt_q;
  assign init_done   = dll_exp && zq_exp && (st_q == ST_RUN);

endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_reset_n,
  input logic          mem_cke,
  input logic          mem_odt,
  input logic          mem_cs_n,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic [2:0]    mem_ba,
  input logic [AW-1:0] mem_addr,
  input logic          init_done
);

  logic is_mrs;
  assign is_mrs = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;

  // R3
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> mem_cs_n);

  // R10
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cke && $past(mem_cke)) |-> $past(start));

  // R5
  mrs_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> !mem_ba[2]);

  // R6
  mr1_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mem_ba == 3'b001) |-> !mem_addr[0]);

  // R7
  mr0_dllrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mem_ba == 3'b000) |-> mem_addr[8]);

  // R9
  done_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (mem_cke && mem_reset_n));

  // R11
  odt_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_reset_n && $past(mem_reset_n)) |-> $stable(mem_odt));

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (!mem_reset_n && !init_done));

endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mem_reset_n (mem_reset_n),
  .mem_cke     (mem_cke),
  .mem_odt     (mem_odt),
  .mem_cs_n    (mem_cs_n),
  .mem_ras_n   (mem_ras_n),
  .mem_cas_n   (mem_cas_n),
  .mem_we_n    (mem_we_n),
  .mem_ba      (mem_ba),
  .mem_addr    (mem_addr),
  .init_done   (init_done)
);

// File: tb/sim_ddr3_init_seq.sv
`timescale 1ns/1ps
module sim_ddr3_init_seq;

  localparam int AW = 14;
  localparam int PR[2]   = '{4, 2};
  localparam int PC[2]   = '{3, 2};
  localparam int PX[2]   = '{5, 5};
  localparam int PMRD[2] = '{4, 2};
  localparam int PMOD[2] = '{6, 3};
  localparam int PDLL[2] = '{30, 8};
  localparam int PZQ[2]  = '{20, 40};

  // {strobes[3:0], ba[2:0], addr[13:0]}
  localparam logic [20:0] EXP [10] = '{
    {4'h0, 3'd2, 14'h0018}, {4'h0, 3'd3, 14'h0000}, {4'h0, 3'd1, 14'h0000},
    {4'h0, 3'd0, 14'h0520}, {4'h6, 3'd0, 14'h0400},
    {4'h0, 3'd2, 14'h0008}, {4'h0, 3'd3, 14'h0004}, {4'h0, 3'd1, 14'h0040},
    {4'h0, 3'd0, 14'h1D71}, {4'h6, 3'd0, 14'h0400}
  };

  logic clk = 1'b0;
  logic rst_n, start, odt_req;
  logic [AW-1:0] mr0, mr1, mr2, mr3;
  logic mreset_n[2], mcke[2], modt[2], mcs[2], mras[2], mcas[2], mwe[2], done[2];
  logic [2:0]    mba[2];
  logic [AW-1:0] maddr[2];

  always #5 clk = ~clk;

  ddr3_init_seq #(.AW(AW), .T_RESET_LOW(4), .T_RST_CKE(3), .T_XPR(5), .T_MRD(4),
                  .T_MOD(6), .T_DLLK(30), .T_ZQINIT(20)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .odt_req(odt_req),
    .mr0_word(mr0), .mr1_word(mr1), .mr2_word(mr2), .mr3_word(mr3),
    .mem_reset_n(mreset_n[0]), .mem_cke(mcke[0]), .mem_odt(modt[0]),
    .mem_cs_n(mcs[0]), .mem_ras_n(mras[0]), .mem_cas_n(mcas[0]), .mem_we_n(mwe[0]),
    .mem_ba(mba[0]), .mem_addr(maddr[0]), .init_done(done[0]));

  ddr3_init_seq #(.AW(AW), .T_RESET_LOW(2), .T_RST_CKE(2), .T_XPR(5), .T_MRD(2),
                  .T_MOD(3), .T_DLLK(8), .T_ZQINIT(40)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .odt_req(odt_req),
    .mr0_word(mr0), .mr1_word(mr1), .mr2_word(mr2), .mr3_word(mr3),
    .mem_reset_n(mreset_n[1]), .mem_cke(mcke[1]), .mem_odt(modt[1]),
    .mem_cs_n(mcs[1]), .mem_ras_n(mras[1]), .mem_cas_n(mcas[1]), .mem_we_n(mwe[1]),
    .mem_ba(mba[1]), .mem_addr(maddr[1]), .init_done(done[1]));

  int checks = 0, fails = 0, cyc = 0;
  int n_cmd[2], t_rrise[2], t_crise[2], t_done[2], rst_low[2];
  int cke_fall[2], desel_bad[2], nop_bad[2], odt_chg[2];
  logic [20:0] clog[2][8];
  int tcmd[2][8];
  logic p_rst[2], p_cke[2], p_odt[2], p_done[2];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int k = 0; k < 2; k++) begin
      n_cmd[k] = 0; t_rrise[k] = -1; t_crise[k] = -1; t_done[k] = -1;
      rst_low[k] = 0; cke_fall[k] = 0; desel_bad[k] = 0; nop_bad[k] = 0;
      odt_chg[k] = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 2; k++) begin
      logic [3:0] c;
      c = {mcs[k], mras[k], mcas[k], mwe[k]};
      if (!mreset_n[k]) rst_low[k]++;
      if (mreset_n[k] && !p_rst[k]) t_rrise[k] = cyc;
      if (mcke[k] && !p_cke[k]) t_crise[k] = cyc;
      if (!mcke[k] && p_cke[k] && mreset_n[k]) cke_fall[k]++;
      if (!mcke[k] && !mcs[k]) desel_bad[k]++;
      if (mcke[k]) begin
        if (c == 4'h0 || c == 4'h6) begin
          if (n_cmd[k] < 8) begin
            clog[k][n_cmd[k]] = {c, mba[k], maddr[k]};
            tcmd[k][n_cmd[k]] = cyc;
          end
          n_cmd[k]++;
        end else if (c != 4'h7) nop_bad[k]++;
      end
      if (mreset_n[k] && p_rst[k] && modt[k] != p_odt[k]) odt_chg[k]++;
      if (done[k] && !p_done[k]) t_done[k] = cyc;
      p_rst[k] = mreset_n[k]; p_cke[k] = mcke[k]; p_odt[k] = modt[k]; p_done[k] = done[k];
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!(done[0] && done[1]) && n < 3000) begin
      @(negedge clk); n++;
    end
    check(n < 3000, "R9", "watchdog waiting for init_done", n, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic launch();
    @(negedge clk); #1;
    clear_log();
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(!mreset_n[k], "R12", "reset_n after start", int'(mreset_n[k]), 0);
      check(!done[k], "R12", "init_done after start", int'(done[k]), 0);
    end
    #1 start = 1'b0;
  endtask

  task automatic verify(input int k, input int base, input logic exp_odt,
                        input bit chk_rl);
    int exp_done;
    if (chk_rl) check(rst_low[k] == PR[k], "R2", "reset low cycles", rst_low[k], PR[k]);
    check(t_crise[k] - t_rrise[k] == PC[k], "R2", "reset->cke", t_crise[k] - t_rrise[k], PC[k]);
    check(n_cmd[k] == 5, "R5", "command count", n_cmd[k], 5);
    check(tcmd[k][0] - t_crise[k] == PX[k], "R4", "cke->first MRS", tcmd[k][0] - t_crise[k], PX[k]);
    for (int i = 0; i < 5; i++) begin
      string rq;
      rq = (i == 2) ? "R6" : (i == 3) ? "R7" : (i == 4) ? "R8" : "R5";
      check(clog[k][i] == EXP[base + i], rq, $sformatf("command %0d word", i),
            int'(clog[k][i]), int'(EXP[base + i]));
    end
    for (int i = 0; i < 3; i++)
      check(tcmd[k][i+1] - tcmd[k][i] == PMRD[k], "R5", "MRS spacing",
            tcmd[k][i+1] - tcmd[k][i], PMRD[k]);
    check(tcmd[k][4] - tcmd[k][3] == PMOD[k], "R8", "MR0->ZQCL",
          tcmd[k][4] - tcmd[k][3], PMOD[k]);
    exp_done = (tcmd[k][3] + PDLL[k] > tcmd[k][4] + PZQ[k]) ?
               tcmd[k][3] + PDLL[k] : tcmd[k][4] + PZQ[k];
    check(t_done[k] == exp_done, "R9", "ready cycle", t_done[k], exp_done);
    check(done[k], "R9", "ready held", int'(done[k]), 1);
    check(cke_fall[k] == 0, "R10", "cke drops", cke_fall[k], 0);
    check(desel_bad[k] == 0, "R3", "select while cke low", desel_bad[k], 0);
    check(nop_bad[k] == 0, "R3", "non-NOP idle cycles", nop_bad[k], 0);
    check(odt_chg[k] == 0, "R11", "odt changes", odt_chg[k], 0);
    check(modt[k] == exp_odt, "R11", "odt level", int'(modt[k]), int'(exp_odt));
  endtask

  initial begin
    #1500000;
    check(1'b0, "R9", "global watchdog", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; odt_req = 1'b1;
    mr2 = 14'h0018; mr3 = 14'h0000; mr1 = 14'h0001; mr0 = 14'h0420;
    for (int k = 0; k < 2; k++) begin
      p_rst[k] = 1'b0; p_cke[k] = 1'b0; p_odt[k] = 1'b0; p_done[k] = 1'b0;
    end
    clear_log();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(!mreset_n[k], "R1", "reset_n in reset", int'(mreset_n[k]), 0);
      check(!mcke[k], "R1", "cke in reset", int'(mcke[k]), 0);
      check(mcs[k], "R1", "cs_n in reset", int'(mcs[k]), 1);
      check(!done[k], "R1", "init_done in reset", int'(done[k]), 0);
    end
    #1 clear_log();
    rst_n = 1'b1;
    wait_done();
    // run A: DLL bits forced, ODT follows odt_req
    verify(0, 0, 1'b1, 1'b0);
    verify(1, 0, 1'b1, 1'b0);

    // run B: termination enabled in MR1, ODT must be low
    mr2 = 14'h0008; mr3 = 14'h0004; mr1 = 14'h0041; mr0 = 14'h1D71;
    launch();
    wait_done();
    verify(0, 5, 1'b0, 1'b1);
    verify(1, 5, 1'b0, 1'b1);

    // run C: restart in the middle of the mode-register writes
    mr2 = 14'h0018; mr3 = 14'h0000; mr1 = 14'h0001; mr0 = 14'h0420; odt_req = 1'b0;
    launch();
    while (n_cmd[0] < 2) @(negedge clk);
    launch();
    wait_done();
    verify(0, 0, 1'b0, 1'b1);
    verify(1, 0, 1'b0, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule